// File: doc/BRIEF.md
# Image Scaler Control and Interrupt Register Block

This block is the register-side controller of an image scaler engine. Software reaches it through a simple memory-mapped port: one write strobe, one read strobe, a word address and a data word each way. Through it software launches frames, resets the datapath, selects which interrupt causes may reach the interrupt line, and acknowledges pending causes. It also arms a watchdog timer so that a stalled frame ends in an interrupt.

The datapath sends back a frame-completion pulse and a vector of error pulses. Each pulse latches into a pending bit. The interrupt line is a level: it is high while any pending bit is also enabled. A frame counts as good only when its completion bit is pending; every other pending cause marks a failed frame.

A soft reset holds the datapath in reset for a fixed number of cycles. While it runs, the reset flag reads back as set and register writes have no effect. When it ends, the flag clears by itself, and software can confirm the block is ready by writing 1 to the enable register and reading 1 back. The block carries no data streams, so it has no valid/ready interface and no back-pressure rules; all pins are plain control and status.

Top module: `scl_ctrl_regs`

## Requirements
- R1: After rst_n is released, every register reads 0, and irq_o, start_o and dp_rst_o are all low.
- R2: Writing 1 to bit 1 of the control word (address 0) raises dp_rst_o for exactly 8 cycles. During that time bit 1 of address 0 reads 1. In the cycle after dp_rst_o falls, the pending and enable registers are both 0.
- R3: While dp_rst_o is high, every register write is ignored, including a start request. Once the reset has ended, writing 1 to the enable register (address 1) reads back exactly 1.
- R4: A write to address 0 with bit 0 set and bit 1 clear, made outside a soft reset, drives start_o high for exactly the cycle after the write. Bit 0 of address 0 always reads 0.
- R5: The pending register (address 2) uses this layout: bit 0 is frame completion, bit 1 is watchdog expiry, and bit 2+i is err_i[i]. An event pulse sets its bit whether or not that bit is enabled.
- R6: Writing a word to address 2 clears exactly the pending bits that hold 1 in that word. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: irq_o is high exactly when some pending bit is also enabled. Writing 0 to address 1 makes irq_o low in the next cycle.
- R8: The watchdog word (address 3) holds an enable in bit 0, a 16-bit count in bits 16:1 and a 4-bit prescale exponent in bits 20:17. It reads back as written, and all-ones fields are accepted.
- R9: When the watchdog is enabled with count V and exponent D, it sets pending bit 1 exactly (V+1)*2^D cycles after the start write. A frame-completion pulse, a soft reset, or a start made while the watchdog is disabled stops it, and no expiry follows.
- R10: A start made while the watchdog is running reloads it, and the expiry time is counted from the later start.
- R11: A read of an address above 3 returns 0, and reg_rdata is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; gates reg_rdata |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| frame_end_i | input | 1 | Frame-completion pulse from the datapath |
| err_i | input | 24 | Error-condition pulses from the datapath |
| irq_o | output | 1 | Level interrupt request |
| start_o | output | 1 | One-cycle frame launch pulse |
| dp_rst_o | output | 1 | Datapath reset, held during a soft reset |

## Verification
The bench builds the block with its default parameters: 24 error inputs, an 8-cycle soft reset, a 16-bit count and a 4-bit prescale exponent. At run time it programs the watchdog with small counts and exponents of 0 and 1. This keeps expiry within a few cycles of the start, so expiry timing, reloads, and the races between completion pulses and expiry can be checked exactly. All-ones watchdog fields are checked through readback only, because a full-length expiry would take about 2^31 cycles.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // word addresses of the register file (low address bits)
  localparam int SEL_W     = 2;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_IEN  = 1;
  localparam int ADDR_PEND = 2;
  localparam int ADDR_WDOG = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_WDOG = 2'd3
  } reg_sel_e;

  // control word bits
  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;

  // pending / enable layout
  localparam int PEND_DONE_BIT = 0;
  localparam int PEND_WDOG_BIT = 1;
  localparam int PEND_ERR_LSB  = 2;

endpackage

// File: rtl/scl_srst_seq.sv
module scl_srst_seq #(
  parameter int SRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SRST_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);

endmodule

// File: rtl/scl_wdog.sv
module scl_wdog #(
  parameter int TMR_W = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             abort_i,
  input  logic             en_cfg_i,
  input  logic [TMR_W-1:0] cnt_cfg_i,
  input  logic [DIV_W-1:0] div_cfg_i,
  output logic             fire_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             run_q;
  logic [TMR_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_lim;
  logic             tick;

  assign pre_lim = {PRE_W{1'b1}} >> (PRE_W - int'(div_q));
  assign tick    = (pre_q == pre_lim);
  assign fire_o  = run_q && tick && (cnt_q == '0) && !halt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      pre_q <= '0;
      div_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
    end else if (go_i) begin
      run_q <= en_cfg_i;
      cnt_q <= cnt_cfg_i;
      div_q <= div_cfg_i;
      pre_q <= '0;
    end else if (run_q) begin
      if (halt_i || fire_o) begin
        run_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
        pre_q <= '0;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_irq_bank.sv
module scl_irq_bank #(
  parameter int N_SRC = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe_i,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic             ien_we_i,
  input  logic [N_SRC-1:0] ien_wdata_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] ien_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ien_q  <= '0;
    end else if (wipe_i) begin
      pend_q <= '0;
      ien_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~ack_i) | set_i;
      if (ien_we_i) ien_q <= ien_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign ien_o  = ien_q;
  assign irq_o  = |(pend_q & ien_q);

endmodule

// File: rtl/scl_ctrl_regs.sv
module scl_ctrl_regs
  import scl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int N_ERR       = 24,
  parameter int SRST_CYCLES = 8,
  parameter int TMR_W       = 16,
  parameter int DIV_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_end_i,
  input  logic [N_ERR-1:0]  err_i,
  output logic              irq_o,
  output logic              start_o,
  output logic              dp_rst_o
);
  localparam int N_SRC    = N_ERR + PEND_ERR_LSB;
  localparam int WD_CNT_L = 1;
  localparam int WD_DIV_L = WD_CNT_L + TMR_W;
  localparam int WD_USED  = WD_DIV_L + DIV_W;

  // address decode
  logic     hit;
  reg_sel_e sel;
  assign hit = (reg_addr[ADDR_W-1:SEL_W] == '0);
  assign sel = reg_sel_e'(reg_addr[SEL_W-1:0]);

  logic busy, done;
  logic wr_ok;
  logic wr_ctrl, wr_ien, wr_pend, wr_wdog;
  logic srst_req, go_req;

  assign wr_ok    = reg_wr && hit && !busy;
  assign wr_ctrl  = wr_ok && (sel == SEL_CTRL);
  assign wr_ien   = wr_ok && (sel == SEL_IEN);
  assign wr_pend  = wr_ok && (sel == SEL_PEND);
  assign wr_wdog  = wr_ok && (sel == SEL_WDOG);
  assign srst_req = wr_ctrl && reg_wdata[CTRL_SRST_BIT];
  assign go_req   = wr_ctrl && reg_wdata[CTRL_GO_BIT] && !reg_wdata[CTRL_SRST_BIT];

  scl_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (srst_req),
    .busy_o (busy),
    .done_o (done)
  );

  // watchdog configuration word
  logic [WD_USED-1:0] wdog_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdog_q <= '0;
    else if (wr_wdog) wdog_q <= reg_wdata[WD_USED-1:0];
  end

  logic wd_fire;
  scl_wdog #(.TMR_W(TMR_W), .DIV_W(DIV_W)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_req),
    .halt_i    (frame_end_i),
    .abort_i   (srst_req),
    .en_cfg_i  (wdog_q[0]),
    .cnt_cfg_i (wdog_q[WD_DIV_L-1:WD_CNT_L]),
    .div_cfg_i (wdog_q[WD_USED-1:WD_DIV_L]),
    .fire_o    (wd_fire)
  );

  // event vector, gated while the datapath is held in reset
  logic [N_SRC-1:0] ev_set, ev_ack, pend, ien;
  always_comb begin
    ev_set = '0;
    if (!busy) begin
      ev_set[PEND_DONE_BIT] = frame_end_i;
      ev_set[PEND_WDOG_BIT] = wd_fire;
      ev_set[N_SRC-1:PEND_ERR_LSB] = err_i;
    end
  end
  assign ev_ack = wr_pend ? reg_wdata[N_SRC-1:0] : '0;

  scl_irq_bank #(.N_SRC(N_SRC)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wipe_i      (done),
    .set_i       (ev_set),
    .ack_i       (ev_ack),
    .ien_we_i    (wr_ien),
    .ien_wdata_i (reg_wdata[N_SRC-1:0]),
    .pend_o      (pend),
    .ien_o       (ien),
    .irq_o       (irq_o)
  );

  // launch pulse
  logic go_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= go_req;
  end
  assign start_o  = go_q;
  assign dp_rst_o = busy;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd && hit) begin
      unique case (sel)
        SEL_CTRL: reg_rdata[CTRL_SRST_BIT] = busy;
        SEL_IEN:  reg_rdata[N_SRC-1:0]     = ien;
        SEL_PEND: reg_rdata[N_SRC-1:0]     = pend;
        SEL_WDOG: reg_rdata[WD_USED-1:0]   = wdog_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/scl_ctrl_regs_chk.sv
module scl_ctrl_regs_chk
  import scl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int N_SRC       = 26,
  parameter int SRST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              frame_end_i,
  input logic              irq_o,
  input logic              start_o,
  input logic              dp_rst_o,
  input logic [N_SRC-1:0]  pend
);
  int unsigned rst_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rst_run <= 0;
    else if (dp_rst_o) rst_run <= rst_run + 1;
    else               rst_run <= 0;
  end

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_no_start_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !dp_rst_o);

  p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ADDR_IEN) && reg_wdata == '0 && !dp_rst_o) |=> !irq_o);

  p_done_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !dp_rst_o) |=> pend[PEND_DONE_BIT]);

  p_reset_wipes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst_o) |-> (pend == '0 && !irq_o));

  p_reset_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst_o |-> (rst_run < SRST_CYCLES));

  p_reset_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_rst_o) |-> (rst_run == SRST_CYCLES));

endmodule

bind scl_ctrl_regs scl_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC), .SRST_CYCLES(SRST_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .frame_end_i (frame_end_i),
  .irq_o       (irq_o),
  .start_o     (start_o),
  .dp_rst_o    (dp_rst_o),
  .pend        (pend)
);

// File: tb/scl_ctrl_regs_test.sv
module scl_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_wr = 1'b0, i_rd = 1'b0;
  logic [3:0]  i_addr = '0;
  logic [31:0] i_wdata = '0;
  logic        i_fe = 1'b0;
  logic [23:0] i_err = '0;
  logic [31:0] rdata;
  logic        irq, start, dprst;

  scl_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(i_wr), .reg_rd(i_rd), .reg_addr(i_addr),
    .reg_wdata(i_wdata), .reg_rdata(rdata), .frame_end_i(i_fe), .err_i(i_err),
    .irq_o(irq), .start_o(start), .dp_rst_o(dprst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    done_flag = 0;
  string ph = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [25:0] m_pend, m_ien;
  int        m_left;
  bit        m_run, m_go, m_wd_en;
  longint    m_rem;
  int        m_wd_v, m_wd_d;
  bit        started = 0;

  always @(posedge clk) begin
    bit [25:0] s, c;
    bit        ng;
    started = 1;
    s = '0; c = '0; ng = 0;
    if (!rst_n) begin
      m_pend = '0; m_ien = '0; m_left = 0; m_run = 0; m_wd_en = 0;
      m_rem = 0; m_wd_v = 0; m_wd_d = 0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin m_pend = '0; m_ien = '0; end
    end else begin
      s[0] = i_fe;
      s[25:2] = i_err;
      if (m_run) begin
        if (i_fe) m_run = 0;
        else begin
          m_rem--;
          if (m_rem == 0) begin s[1] = 1; m_run = 0; end
        end
      end
      if (i_wr) begin
        case (i_addr)
          4'd0: if (i_wdata[1]) begin m_left = 8; m_run = 0; end
                else if (i_wdata[0]) begin
                  ng = 1; m_run = m_wd_en;
                  m_rem = (longint'(m_wd_v) + 1) << m_wd_d;
                end
          4'd1: m_ien = i_wdata[25:0];
          4'd2: c = i_wdata[25:0];
          4'd3: begin
                  m_wd_en = i_wdata[0]; m_wd_v = int'(i_wdata[16:1]);
                  m_wd_d = int'(i_wdata[20:17]);
                end
          default: ;
        endcase
      end
      m_pend = (m_pend & ~c) | s;
    end
    m_go = rst_n ? ng : 1'b0;
  end

  function automatic logic [31:0] exp_rd();
    if (!i_rd) return 32'h0;
    case (i_addr)
      4'd0: return {30'h0, (m_left > 0), 1'b0};
      4'd1: return {6'h0, m_ien};
      4'd2: return {6'h0, m_pend};
      4'd3: return {11'h0, 4'(m_wd_d), 16'(m_wd_v), m_wd_en};
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      chk(ph, "model irq_o", {31'h0, irq}, {31'h0, |(m_pend & m_ien)});
      chk(ph, "model start_o", {31'h0, start}, {31'h0, m_go});
      chk(ph, "model dp_rst_o", {31'h0, dprst}, {31'h0, (m_left > 0)});
      chk(ph, "model reg_rdata", rdata, exp_rd());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nxt();
    @(posedge clk); #1;
    i_fe = 1'b0; i_err = '0;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    i_wr = 1'b1; i_addr = a; i_wdata = d;
    nxt();
    i_wr = 1'b0; i_wdata = '0;
  endtask

  task automatic rd_chk(logic [3:0] a, logic [31:0] exp, string req);
    i_rd = 1'b1; i_addr = a; #1;
    chk(req, "register read", rdata, exp);
    i_rd = 1'b0;
  endtask

  task automatic count_to_irq(int exp, string req);
    int n = 0;
    while (!irq && n < 2000) begin nxt(); n++; end
    chk(req, "cycles to expiry", 32'(n), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    nxt();

    // R1 reset state
    ph = "R1";
    for (int a = 0; a < 4; a++) rd_chk(4'(a), 32'h0, "R1");
    chk("R1", "irq/start/dp_rst", {29'h0, irq, start, dprst}, 32'h0);

    // R4 launch pulse
    ph = "R4";
    wr_reg(4'd0, 32'h1);
    chk("R4", "start_o after go", {31'h0, start}, 32'h1);
    nxt();
    chk("R4", "start_o one cycle", {31'h0, start}, 32'h0);
    rd_chk(4'd0, 32'h0, "R4");

    // R5 pending layout, masked
    ph = "R5";
    i_fe = 1'b1; i_err = 24'h800001;
    nxt();
    rd_chk(4'd2, 32'h0200_0005, "R5");
    chk("R5", "irq_o masked", {31'h0, irq}, 32'h0);

    // R7 level interrupt
    ph = "R7";
    wr_reg(4'd1, 32'h4);
    chk("R7", "irq_o enabled", {31'h0, irq}, 32'h1);
    wr_reg(4'd1, 32'h0);
    chk("R7", "irq_o after mask 0", {31'h0, irq}, 32'h0);

    // R6 acknowledge semantics
    ph = "R6";
    i_err = 24'h1;
    wr_reg(4'd2, 32'h4);
    rd_chk(4'd2, 32'h0200_0005, "R6");
    wr_reg(4'd2, 32'h1);
    rd_chk(4'd2, 32'h0200_0004, "R6");
    wr_reg(4'd2, 32'h03FF_FFFF);
    rd_chk(4'd2, 32'h0, "R6");

    // R8 watchdog word
    ph = "R8";
    wr_reg(4'd3, 32'hFFFF_FFFF);
    rd_chk(4'd3, 32'h001F_FFFF, "R8");
    wr_reg(4'd3, 32'h1 | (32'd3 << 1) | (32'd1 << 17));
    rd_chk(4'd3, 32'h0002_0007, "R8");

    // R9 expiry timing V=3 D=1
    ph = "R9";
    wr_reg(4'd1, 32'h2);
    wr_reg(4'd0, 32'h1);
    count_to_irq(8, "R9");
    wr_reg(4'd2, 32'h2);
    // V=5 D=0
    wr_reg(4'd3, 32'h1 | (32'd5 << 1));
    wr_reg(4'd0, 32'h1);
    count_to_irq(6, "R9");
    wr_reg(4'd2, 32'h2);
    // frame end halts
    wr_reg(4'd3, 32'h1 | (32'd3 << 1) | (32'd1 << 17));
    wr_reg(4'd0, 32'h1);
    nxt(); nxt();
    i_fe = 1'b1;
    nxt();
    repeat (20) nxt();
    rd_chk(4'd2, 32'h1, "R9");
    chk("R9", "irq_o after halt", {31'h0, irq}, 32'h0);
    wr_reg(4'd2, 32'h1);
    // disabled watchdog
    wr_reg(4'd3, 32'h0);
    wr_reg(4'd0, 32'h1);
    repeat (12) nxt();
    rd_chk(4'd2, 32'h0, "R9");

    // R10 reload
    ph = "R10";
    wr_reg(4'd3, 32'h1 | (32'd3 << 1) | (32'd1 << 17));
    wr_reg(4'd0, 32'h1);
    repeat (5) nxt();
    wr_reg(4'd0, 32'h1);
    count_to_irq(8, "R10");
    wr_reg(4'd2, 32'h2);

    // R2 soft reset length
    ph = "R2";
    begin
      int c = 0;
      wr_reg(4'd0, 32'h2);
      while (dprst && c < 100) begin c++; nxt(); end
      chk("R2", "dp_rst_o cycles", 32'(c), 32'd8);
    end
    rd_chk(4'd1, 32'h0, "R2");
    rd_chk(4'd2, 32'h0, "R2");

    // R3 writes ignored during reset, timer aborted
    ph = "R3";
    wr_reg(4'd1, 32'h2);
    wr_reg(4'd0, 32'h1);
    nxt();
    wr_reg(4'd0, 32'h2);
    rd_chk(4'd0, 32'h2, "R2");
    wr_reg(4'd1, 32'h03FF_FFFF);
    wr_reg(4'd3, 32'h0);
    wr_reg(4'd0, 32'h1);
    chk("R3", "start_o during reset", {31'h0, start}, 32'h0);
    while (dprst) nxt();
    rd_chk(4'd1, 32'h0, "R3");
    rd_chk(4'd3, 32'h0002_0007, "R3");
    repeat (20) nxt();
    rd_chk(4'd2, 32'h0, "R9");
    wr_reg(4'd1, 32'h1);
    rd_chk(4'd1, 32'h1, "R3");

    // R11 unmapped and gated reads
    ph = "R11";
    rd_chk(4'd5, 32'h0, "R11");
    rd_chk(4'd15, 32'h0, "R11");
    i_rd = 1'b0; i_addr = 4'd1; #1;
    chk("R11", "rdata with reg_rd low", rdata, 32'h0);

    nxt(); nxt();
    finish_run();
  end

endmodule